// File: doc/BRIEF.md
# Field-Mapped Configuration Register Bank

This block holds a small set of control and status fields behind a single-cycle configuration bus. Software writes through a port carrying an address and a data word, and reads through a combinational port that returns the word at the address presented in the same cycle. Each field has its own bus address, bit offset and access mode: read/write, write-only, write-one-to-clear or read-only. The surrounding design logic sees every field as an ordinary register with its own value and write strobe.

Three words are populated. Word 0 carries a single write-only kick bit. Word 1 is the setup word with an init field, a tz field and an 8-bit counter. Word 2 is the status word with two sticky flags that are cleared by writing ones.

The local logic is built in. The counter advances by one every cycle until it saturates at all ones. The "ones" flag is raised while the counter is saturated. The error flag is raised by an external event pulse. When a bus write and a local update hit the same field in the same cycle, a fixed priority settles the result.

Top module: `cfg_reg_bank`

## Requirements
- R1: A bus write changes a field only when `wr_addr` equals that field's word address. Writes to other addresses, including the unmapped address 3, leave every field unchanged.
- R2: `rd_data` is the OR of the readable fields mapped at `rd_addr`, in the same cycle. Address 3 reads as zero.
- R3: Word 1 places init at bits 3:0, tz at bits 9:4 and the counter at bits 23:16.
- R4: Word 2 places the ones flag at bit 0 and the error flag at bit 1. Word 0 places the kick bit at bit 0.
- R5: On a write to word 2, a 1 in a flag's bit position clears that flag and a 0 leaves it unchanged.
- R6: Data bits outside any field are dropped. Writing 0xFFFFFFFF to word 1 reads back as 0x00FF03FF.
- R7: The kick bit takes the written value on its output but always reads as zero on the bus.
- R8: Reset sets the counter to 1 and every other field to 0.
- R9: With no bus write to word 1, the counter increments by one each cycle until it reaches 255, then holds at 255.
- R10: The ones flag is set in the cycle after one in which the counter equals 255.
- R11: A bus write to word 1 overrides the counter's local increment in that cycle.
- R12: On a flag, a local set in the same cycle as a bus clear of that bit leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write word address |
| wr_data | input | 32 | Bus write data |
| rd_addr | input | 2 | Bus read word address |
| rd_data | output | 32 | Bus read data for `rd_addr`, combinational |
| err_event | input | 1 | Local event that sets the error flag |
| kick_q | output | 1 | Kick field value |
| init_q | output | 4 | Init field value |
| tz_q | output | 6 | Tz field value |
| count_q | output | 8 | Counter field value |
| ones_q | output | 1 | Ones flag value |
| err_q | output | 1 | Error flag value |

## Verification
The hardest case to reach is a clear of the ones flag in the same cycle that the local logic sets it. That only happens while the counter is saturated, so it needs a long counter run with no write to the setup word.

The stimulus rewinds the counter to zero, waits at the ports until it reads 255, and then issues the clear. The same-cycle conflict on the error flag is produced by asserting `err_event` together with a write to word 2. A pseudo-random phase afterwards mixes every address, access mode and event against the cycle model.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
   typedef enum logic [1:0] {
      MODE_RO  = 2'd0,
      MODE_RW  = 2'd1,
      MODE_WO  = 2'd2,
      MODE_W1C = 2'd3
   } cfg_mode_e;
endpackage

// File: rtl/cfgbank_field.sv
module cfgbank_field
   import cfgbank_pkg::*;
#(
   parameter int        AW     = 2,
   parameter int        DW     = 32,
   parameter int        WIDTH  = 1,
   parameter int        ADDR   = 0,
   parameter int        OFFSET = 0,
   parameter cfg_mode_e MODE   = MODE_RW,
   parameter logic [WIDTH-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_waddr,
   input  logic [WIDTH-1:0] bus_bits,
   input  logic [AW-1:0]    bus_raddr,
   input  logic             loc_we,
   input  logic [WIDTH-1:0] loc_wdata,
   output logic [WIDTH-1:0] value,
   output logic [DW-1:0]    rd_contrib
);
   localparam logic [AW-1:0] MY_ADDR  = AW'(ADDR);
   localparam bit            READABLE = (MODE != MODE_WO);

   if (OFFSET + WIDTH > DW) begin : g_bad_span
      $error("field span exceeds data width");
   end
   if (ADDR >= (1 << AW)) begin : g_bad_addr
      $error("field address out of range");
   end

   logic             hit_w;
   logic             hit_r;
   logic [WIDTH-1:0] nxt;

   assign hit_w = bus_we && (bus_waddr == MY_ADDR);
   assign hit_r = (bus_raddr == MY_ADDR);

   if (MODE == MODE_RO) begin : g_ro
      assign nxt = loc_we ? loc_wdata : value;
   end else if (MODE == MODE_W1C) begin : g_w1c
      logic [WIDTH-1:0] clr_m;
      logic [WIDTH-1:0] set_m;
      assign clr_m = hit_w  ? bus_bits  : '0;
      assign set_m = loc_we ? loc_wdata : '0;
      assign nxt   = (value & ~clr_m) | set_m;

      // R12
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         loc_we |=> ((value & $past(loc_wdata)) == $past(loc_wdata)));
      // R5
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_w && !loc_we) |=> ((value & $past(bus_bits)) == '0));
   end else begin : g_rw
      assign nxt = hit_w ? bus_bits : (loc_we ? loc_wdata : value);

      // R11
      bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit_w |=> (value == $past(bus_bits)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= INIT;
      else        value <= nxt;
   end

   assign rd_contrib = (READABLE && hit_r) ? (DW'(value) << OFFSET) : '0;

   // R1
   no_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_w && !loc_we) |=> $stable(value));
endmodule

// File: rtl/cfgbank_rdmux.sv
module cfgbank_rdmux #(
   parameter int NF = 2,
   parameter int DW = 32
) (
   input  logic [NF-1:0][DW-1:0] parts,
   output logic [DW-1:0]         word
);
   always_comb begin
      word = '0;
      for (int i = 0; i < NF; i++) word = word | parts[i];
   end
endmodule

// File: rtl/cfgbank_local.sv
module cfgbank_local #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] count,
   input  logic             err_event,
   output logic             cnt_we,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             ones_we,
   output logic             err_we
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   assign cnt_we  = (count != CNT_MAX);
   assign cnt_nxt = count + CNT_W'(1);
   assign ones_we = (count == CNT_MAX);
   assign err_we  = err_event;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfgbank_pkg::*;
#(
   parameter int AW         = 2,
   parameter int DW         = 32,
   parameter int INIT_W     = 4,
   parameter int TZ_W       = 6,
   parameter int CNT_W      = 8,
   parameter int ADDR_KICK  = 0,
   parameter int ADDR_SETUP = 1,
   parameter int ADDR_STAT  = 2,
   parameter int OFF_INIT   = 0,
   parameter int OFF_TZ     = 4,
   parameter int OFF_CNT    = 16,
   parameter int OFF_ONES   = 0,
   parameter int OFF_ERR    = 1,
   parameter int OFF_KICK   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic              err_event,
   output logic              kick_q,
   output logic [INIT_W-1:0] init_q,
   output logic [TZ_W-1:0]   tz_q,
   output logic [CNT_W-1:0]  count_q,
   output logic              ones_q,
   output logic              err_q
);
   localparam int NF = 6;
   localparam int F_KICK = 0, F_INIT = 1, F_TZ = 2, F_CNT = 3, F_ONES = 4, F_ERR = 5;
   localparam logic [CNT_W-1:0] CNT_MAX   = '1;
   localparam logic [AW-1:0]    SETUP_A   = AW'(ADDR_SETUP);
   localparam logic [AW-1:0]    UNMAPPED  = AW'(3);

   if (OFF_TZ < OFF_INIT + INIT_W || OFF_CNT < OFF_TZ + TZ_W) begin : g_overlap
      $error("setup fields overlap");
   end
   if (OFF_ONES == OFF_ERR) begin : g_flag_overlap
      $error("status flags overlap");
   end

   logic [NF-1:0][DW-1:0] parts;
   logic                  cnt_we, ones_we, err_we;
   logic [CNT_W-1:0]      cnt_nxt;
   wire                   unused_wdata = ^wr_data;

   cfgbank_local #(.CNT_W(CNT_W)) u_local (
      .count(count_q), .err_event(err_event),
      .cnt_we(cnt_we), .cnt_nxt(cnt_nxt), .ones_we(ones_we), .err_we(err_we)
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(1), .ADDR(ADDR_KICK), .OFFSET(OFF_KICK),
                   .MODE(MODE_WO), .INIT(1'b0)) u_kick (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_KICK]), .bus_raddr(rd_addr),
      .loc_we(1'b0), .loc_wdata(1'b0), .value(kick_q), .rd_contrib(parts[F_KICK])
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(INIT_W), .ADDR(ADDR_SETUP), .OFFSET(OFF_INIT),
                   .MODE(MODE_RW), .INIT('0)) u_init (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_INIT +: INIT_W]), .bus_raddr(rd_addr),
      .loc_we(1'b0), .loc_wdata('0), .value(init_q), .rd_contrib(parts[F_INIT])
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(TZ_W), .ADDR(ADDR_SETUP), .OFFSET(OFF_TZ),
                   .MODE(MODE_RW), .INIT('0)) u_tz (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_TZ +: TZ_W]), .bus_raddr(rd_addr),
      .loc_we(1'b0), .loc_wdata('0), .value(tz_q), .rd_contrib(parts[F_TZ])
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(CNT_W), .ADDR(ADDR_SETUP), .OFFSET(OFF_CNT),
                   .MODE(MODE_RW), .INIT(CNT_W'(1))) u_cnt (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_CNT +: CNT_W]), .bus_raddr(rd_addr),
      .loc_we(cnt_we), .loc_wdata(cnt_nxt), .value(count_q), .rd_contrib(parts[F_CNT])
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(1), .ADDR(ADDR_STAT), .OFFSET(OFF_ONES),
                   .MODE(MODE_W1C), .INIT(1'b0)) u_ones (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_ONES]), .bus_raddr(rd_addr),
      .loc_we(ones_we), .loc_wdata(1'b1), .value(ones_q), .rd_contrib(parts[F_ONES])
   );

   cfgbank_field #(.AW(AW), .DW(DW), .WIDTH(1), .ADDR(ADDR_STAT), .OFFSET(OFF_ERR),
                   .MODE(MODE_W1C), .INIT(1'b0)) u_err (
      .clk(clk), .rst_n(rst_n), .bus_we(wr_en), .bus_waddr(wr_addr),
      .bus_bits(wr_data[OFF_ERR]), .bus_raddr(rd_addr),
      .loc_we(err_we), .loc_wdata(1'b1), .value(err_q), .rd_contrib(parts[F_ERR])
   );

   cfgbank_rdmux #(.NF(NF), .DW(DW)) u_rdmux (.parts(parts), .word(rd_data));

   // R9
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_MAX && !(wr_en && wr_addr == SETUP_A)) |=> (count_q == CNT_MAX));
   // R9
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != CNT_MAX && !(wr_en && wr_addr == SETUP_A))
      |=> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));
   // R10
   ones_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_MAX) |=> ones_q);
   // R2
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == UNMAPPED) |-> (rd_data == '0));
endmodule

// File: tb/tb_cfg_reg_bank.sv
`timescale 1ns/1ps
module tb_cfg_reg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        err_event = 1'b0;
   logic        kick_q, ones_q, err_q;
   logic [3:0]  init_q;
   logic [5:0]  tz_q;
   logic [7:0]  count_q;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference state
   logic       m_kick, m_ones, m_err;
   logic [3:0] m_init;
   logic [5:0] m_tz;
   logic [7:0] m_cnt;

   always #2 clk = ~clk;

   cfg_reg_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .err_event(err_event),
      .kick_q(kick_q), .init_q(init_q), .tz_q(tz_q), .count_q(count_q),
      .ones_q(ones_q), .err_q(err_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [1:0] a);
      case (a)
         2'd1:    return {8'h00, m_cnt, 6'h00, m_tz, m_init};
         2'd2:    return {30'h0, m_err, m_ones};
         default: return 32'h0;  // word 0 is write-only, word 3 unmapped
      endcase
   endfunction

   always @(posedge clk) begin
      logic [7:0] c0;
      logic       o0, e0;
      if (!rst_n) begin
         m_kick = 0; m_init = 0; m_tz = 0; m_cnt = 8'd1; m_ones = 0; m_err = 0;
      end else begin
         c0 = m_cnt; o0 = m_ones; e0 = m_err;
         if (wr_en && wr_addr == 2'd0) m_kick = wr_data[0];
         if (wr_en && wr_addr == 2'd1) begin
            m_init = wr_data[3:0]; m_tz = wr_data[9:4]; m_cnt = wr_data[23:16];
         end else if (c0 != 8'hFF) begin
            m_cnt = c0 + 8'd1;
         end
         if (wr_en && wr_addr == 2'd2) begin
            if (wr_data[0]) o0 = 1'b0;
            if (wr_data[1]) e0 = 1'b0;
         end
         if (c0 == 8'hFF) o0 = 1'b1;
         if (err_event)   e0 = 1'b1;
         m_ones = o0; m_err = e0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 read word", rd_data, model_read(rd_addr));
         chk("R7 kick", {31'h0, kick_q}, {31'h0, m_kick});
         chk("R3 init", {28'h0, init_q}, {28'h0, m_init});
         chk("R3 tz", {26'h0, tz_q}, {26'h0, m_tz});
         chk("R9 count", {24'h0, count_q}, {24'h0, m_cnt});
         chk("R10 ones", {31'h0, ones_q}, {31'h0, m_ones});
         chk("R5 err", {31'h0, err_q}, {31'h0, m_err});
      end
   end

   // each task starts and ends just after a falling edge
   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic ev);
      #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d; err_event = ev;
      @(posedge clk);
      #1;
      wr_en = 1'b0; err_event = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_rd(input logic [1:0] a);
      #1;
      rd_addr = a;
      @(negedge clk);
   endtask

   task automatic pulse_err();
      #1;
      err_event = 1'b1;
      @(posedge clk);
      #1;
      err_event = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] lf;
      rd_addr = 2'd1;
      repeat (3) @(negedge clk);
      // R8: reset values
      chk("R8 count reset", {24'h0, count_q}, 32'd1);
      chk("R8 setup word reset", rd_data, 32'h0001_0000);
      chk("R8 flags reset", {30'h0, err_q, ones_q}, 32'd0);
      chk("R8 init/tz/kick reset", {21'h0, kick_q, tz_q, init_q}, 32'd0);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R6, R11: all ones into setup, local increment loses
      bus_wr(2'd1, 32'hFFFF_FFFF, 1'b0);
      chk("R6 setup readback", rd_data, 32'h00FF_03FF);
      chk("R11 bus beats increment", {24'h0, count_q}, 32'h0000_00FF);
      set_rd(2'd2);
      chk("R10 ones after saturate", {31'h0, ones_q}, 32'd1);
      chk("R4 status word ones bit", rd_data, 32'h0000_0001);

      // rewind counter
      bus_wr(2'd1, 32'h0000_0000, 1'b0);
      chk("R11 counter rewound", {24'h0, count_q}, 32'd0);

      // R7: write-only kick
      set_rd(2'd0);
      bus_wr(2'd0, 32'hFFFF_FFFF, 1'b0);
      chk("R7 kick set", {31'h0, kick_q}, 32'd1);
      chk("R7 kick reads zero", rd_data, 32'd0);

      // R5: clear ones, leave err
      set_rd(2'd2);
      bus_wr(2'd2, 32'h0000_0001, 1'b0);
      chk("R5 ones cleared", {31'h0, ones_q}, 32'd0);
      pulse_err();
      bus_wr(2'd2, 32'h0000_0001, 1'b0);
      chk("R5 zero bit keeps err", {31'h0, err_q}, 32'd1);
      chk("R4 status word err bit", rd_data, 32'h0000_0002);

      // R1: unmapped write and foreign address
      bus_wr(2'd3, 32'hFFFF_FFFF, 1'b0);
      chk("R1 unmapped write kick", {31'h0, kick_q}, 32'd1);
      chk("R1 unmapped write init", {28'h0, init_q}, 32'd0);
      bus_wr(2'd2, 32'h0000_000C, 1'b0);
      chk("R1 status write leaves init", {28'h0, init_q}, 32'd0);
      set_rd(2'd3);
      chk("R2 unmapped reads zero", rd_data, 32'd0);

      // R12: event set beats bus clear on err
      set_rd(2'd2);
      bus_wr(2'd2, 32'h0000_0002, 1'b1);
      chk("R12 err event beats clear", {31'h0, err_q}, 32'd1);

      // R12: wait for saturation, then clear both flags
      while (count_q != 8'hFF) @(negedge clk);
      @(negedge clk);
      bus_wr(2'd2, 32'h0000_0003, 1'b0);
      chk("R12 ones set beats clear", {31'h0, ones_q}, 32'd1);
      chk("R5 err cleared", {31'h0, err_q}, 32'd0);

      // mixed traffic against the model
      lf = 32'hACE1_1234;
      for (int i = 0; i < 600; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         #1;
         wr_en     = lf[0] & lf[3];
         wr_addr   = lf[2:1];
         wr_data   = {lf[15:0], lf[31:16]} ^ {32{lf[9]}};
         rd_addr   = lf[5:4];
         err_event = lf[6] & lf[7] & lf[8];
         @(negedge clk);
      end
      #1 wr_en = 1'b0; err_event = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule